// File: doc/BRIEF.md
# Read-Aware Rank Power Throttle

This block decides, once per throttle period, which memory ranks are worth waking. It watches the status of every slot in a shared request queue (valid, read or write, target rank). A programmable delay counter runs between periods. When it expires, the block takes a snapshot of the queue and groups the valid slots by rank. Only a rank whose group holds at least one read is served. Such a rank is powered on, and its whole group, writes included, is handed to that rank's command queue. Ranks whose groups hold only writes, or nothing, stay in low power. Their writes remain in the request queue until a later period finds a read for the same rank.

Served ranks are released one per cycle, lowest index first. Each release strobe comes with the mask of queue slots that move out. The external queue drops those slots. For each rank the block keeps a count of commands that were released but have not yet completed. When that count drains to zero, the block pulses a power-off request and marks the rank asleep. DRAM timing and any reordering inside a command queue belong to other blocks.

Top module: `rank_wake_throttle`

## Requirements
- R1: A delay counter starts at 0 after reset and after every release phase. It advances once per idle cycle. The throttle expires on the idle cycle in which the counter equals `cfg_delay`, so a delay of 0 expires on every idle cycle. With one served rank per period, the first release strobe comes `cfg_delay`+1 cycles after reset is released. Each later strobe comes `cfg_delay`+2 cycles after the previous one.
- R2: At expiry a rank is served only if some valid slot whose rank field selects it is a read (`rq_is_read` bit = 1). A rank with only writes, or with no slots, receives no `rank_release` strobe.
- R3: A served rank's strobe comes with `rel_entry_mask` set at bit i for every slot i that was valid and targeted that rank at expiry, whether read or write. Slot i's rank is `rq_rank[2i+1:2i]`, and `rank_release` bit r stands for rank r.
- R4: Write-only slots stay unreleased across any number of periods. They are released together with a read as soon as a period finds a read for their rank.
- R5: Served ranks are strobed in ascending rank order, one per cycle, starting in the cycle after expiry. At most one `rank_release` bit is ever set.
- R6: `rank_power_on[r]` pulses together with the strobe of rank r only if rank r is asleep, and `rank_awake[r]` is 1 from the next cycle on. A rank that is still awake gets no power-on pulse.
- R7: Each release adds the number of released slots to the rank's outstanding count. Each `rank_done[r]` pulse removes one command while the count is nonzero. `rank_power_off[r]` pulses in the first cycle the count is zero while the rank is awake and not being released. `rank_awake[r]` drops in the next cycle.
- R8: Slots that become valid during a release phase are not released in that phase. They wait for the next expiry.
- R9: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_delay | input | 16 | Throttle delay in idle cycles |
| rq_valid | input | 8 | Per-slot valid flag of the request queue |
| rq_is_read | input | 8 | Per-slot read (1) or write (0) flag |
| rq_rank | input | 16 | Per-slot target rank, 2 bits per slot |
| rank_done | input | 4 | Per-rank command completion pulse |
| rank_release | output | 4 | Per-rank release strobe, at most one set |
| rel_entry_mask | output | 8 | Queue slots moved out with the current strobe |
| rank_power_on | output | 4 | Per-rank wake request pulse |
| rank_power_off | output | 4 | Per-rank sleep request pulse |
| rank_awake | output | 4 | Per-rank powered state |

## Verification
The main function is exercised with a sweep of arithmetically generated queue contents. The sweep covers empty queues, write-only queues, single-rank queues and queues with reads on several ranks. It separates a correct read-presence decision from one that wakes on any traffic, and a full-group release from one that releases reads only. Directed runs do the rest. One keeps write-only slots parked over several periods before a read arrives. One measures strobe spacing at delays 0, 3 and 9. One injects new reads in the middle of a release phase while an earlier rank is still awake, which exposes a missing snapshot and spurious power-on pulses. Every drain checks that the power-off pulse lands exactly on the cycle the outstanding count reaches zero.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_REL  = 1'b1
    } phase_t;
endpackage

// File: rtl/rwt_cluster.sv
// Groups request-queue slots by target rank and flags ranks that hold a read.
module rwt_cluster #(
    parameter int NUM_RANKS = 4,
    parameter int QDEPTH    = 8,
    parameter int RANK_W    = 2
) (
    input  logic [QDEPTH-1:0]                 rq_valid,
    input  logic [QDEPTH-1:0]                 rq_is_read,
    input  logic [QDEPTH*RANK_W-1:0]          rq_rank,
    output logic [NUM_RANKS-1:0][QDEPTH-1:0]  grp_mask,
    output logic [NUM_RANKS-1:0]              urgent
);
    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
            assign grp_mask[r][i] = rq_valid[i] &&
                (rq_rank[i*RANK_W +: RANK_W] == RANK_W'(r));
        end
        assign urgent[r] = |(grp_mask[r] & rq_is_read);
    end
endmodule

// File: rtl/rwt_pick.sv
// Lowest-index one-hot grant.
module rwt_pick #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] grant
);
    assign grant = req & (~req + WIDTH'(1));
endmodule

// File: rtl/rwt_rank_track.sv
// Per-rank outstanding count and power state.
module rwt_rank_track #(
    parameter int OUT_W = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel,
    input  logic [CNT_W-1:0] rel_cnt,
    input  logic             done,
    output logic             awake,
    output logic             pwr_on,
    output logic             pwr_off
);
    typedef struct packed {
        logic [OUT_W-1:0] outst;
        logic             awake;
    } trk_t;

    trk_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        pwr_on  = rel && !s_q.awake;
        pwr_off = s_q.awake && (s_q.outst == '0) && !rel;
        if (rel) begin
            s_d.outst = s_d.outst + {{(OUT_W-CNT_W){1'b0}}, rel_cnt};
        end
        if (done && (s_q.outst != '0)) begin
            s_d.outst = s_d.outst - OUT_W'(1);
        end
        if (rel) begin
            s_d.awake = 1'b1;
        end else if (pwr_off) begin
            s_d.awake = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign awake = s_q.awake;
endmodule

// File: rtl/rank_wake_throttle.sv
module rank_wake_throttle
    import rwt_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int QDEPTH    = 8,
    parameter int DLY_W     = 16,
    parameter int OUT_W     = 8,
    localparam int RANK_W   = $clog2(NUM_RANKS),
    localparam int CNT_W    = $clog2(QDEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DLY_W-1:0]         cfg_delay,
    input  logic [QDEPTH-1:0]        rq_valid,
    input  logic [QDEPTH-1:0]        rq_is_read,
    input  logic [QDEPTH*RANK_W-1:0] rq_rank,
    input  logic [NUM_RANKS-1:0]     rank_done,
    output logic [NUM_RANKS-1:0]     rank_release,
    output logic [QDEPTH-1:0]        rel_entry_mask,
    output logic [NUM_RANKS-1:0]     rank_power_on,
    output logic [NUM_RANKS-1:0]     rank_power_off,
    output logic [NUM_RANKS-1:0]     rank_awake
);
    typedef struct packed {
        phase_t                            phase;
        logic [DLY_W-1:0]                  tick;
        logic [NUM_RANKS-1:0]              pend;
        logic [NUM_RANKS-1:0][QDEPTH-1:0]  snap;
    } ctl_t;

    ctl_t s_q, s_d;

    logic [NUM_RANKS-1:0][QDEPTH-1:0] grp_mask;
    logic [NUM_RANKS-1:0]             urgent;
    logic [NUM_RANKS-1:0]             sel_oh;
    logic [CNT_W-1:0]                 rel_cnt;

    rwt_cluster #(
        .NUM_RANKS (NUM_RANKS),
        .QDEPTH    (QDEPTH),
        .RANK_W    (RANK_W)
    ) u_cluster (
        .rq_valid   (rq_valid),
        .rq_is_read (rq_is_read),
        .rq_rank    (rq_rank),
        .grp_mask   (grp_mask),
        .urgent     (urgent)
    );

    rwt_pick #(
        .WIDTH (NUM_RANKS)
    ) u_pick (
        .req   (s_q.pend),
        .grant (sel_oh)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_IDLE: begin
                if (s_q.tick >= cfg_delay) begin
                    s_d.tick = '0;
                    s_d.snap = grp_mask;
                    s_d.pend = urgent;
                    s_d.phase = (|urgent) ? PH_REL : PH_IDLE;
                end else begin
                    s_d.tick = s_q.tick + DLY_W'(1);
                end
            end
            default: begin
                s_d.tick = '0;
                s_d.pend = s_q.pend & ~sel_oh;
                if (s_d.pend == '0) begin
                    s_d.phase = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rank_release   = (s_q.phase == PH_REL) ? sel_oh : '0;
        rel_entry_mask = '0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            if (rank_release[r]) begin
                rel_entry_mask = rel_entry_mask | s_q.snap[r];
            end
        end
        rel_cnt = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            rel_cnt = rel_cnt + {{(CNT_W-1){1'b0}}, rel_entry_mask[i]};
        end
    end

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_track
        rwt_rank_track #(
            .OUT_W (OUT_W),
            .CNT_W (CNT_W)
        ) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .rel     (rank_release[r]),
            .rel_cnt (rel_cnt),
            .done    (rank_done[r]),
            .awake   (rank_awake[r]),
            .pwr_on  (rank_power_on[r]),
            .pwr_off (rank_power_off[r])
        );
    end
endmodule

// File: rtl/rwt_checker.sv
module rwt_checker #(
    parameter int NUM_RANKS = 4,
    parameter int QDEPTH    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RANKS-1:0] rank_release,
    input logic [QDEPTH-1:0]    rel_entry_mask,
    input logic [NUM_RANKS-1:0] rank_power_on,
    input logic [NUM_RANKS-1:0] rank_power_off,
    input logic [NUM_RANKS-1:0] rank_awake
);
    a_r5_one_rank_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rank_release));

    a_r3_slots_only_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_entry_mask) |-> (|rank_release));

    a_r7_no_off_during_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_power_off & rank_release) == '0);

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        a_r6_on_needs_sleeping_release: assert property (@(posedge clk) disable iff (!rst_n)
            rank_power_on[r] |-> (rank_release[r] && !rank_awake[r]));

        a_r6_awake_after_release: assert property (@(posedge clk) disable iff (!rst_n)
            rank_release[r] |=> rank_awake[r]);

        a_r7_off_only_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
            rank_power_off[r] |-> rank_awake[r]);

        a_r7_asleep_after_off: assert property (@(posedge clk) disable iff (!rst_n)
            rank_power_off[r] |=> !rank_awake[r]);
    end
endmodule

bind rank_wake_throttle rwt_checker #(
    .NUM_RANKS (NUM_RANKS),
    .QDEPTH    (QDEPTH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rank_release   (rank_release),
    .rel_entry_mask (rel_entry_mask),
    .rank_power_on  (rank_power_on),
    .rank_power_off (rank_power_off),
    .rank_awake     (rank_awake)
);

// File: tb/rank_wake_throttle_tb.sv
`timescale 1ns/1ps
module rank_wake_throttle_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg = 16'd2;
    logic [7:0]  q_v = '0;
    logic [7:0]  q_r = '0;
    logic [15:0] q_rk = '0;
    logic [3:0]  done = '0;
    logic [3:0]  rank_release, rank_power_on, rank_power_off, rank_awake;
    logic [7:0]  rel_entry_mask;

    int errors = 0;
    int checks = 0;
    int exp_out [4];
    bit exp_awake [4];

    always #2.5 clk = ~clk;

    rank_wake_throttle u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_delay      (cfg),
        .rq_valid       (q_v),
        .rq_is_read     (q_r),
        .rq_rank        (q_rk),
        .rank_done      (done),
        .rank_release   (rank_release),
        .rel_entry_mask (rel_entry_mask),
        .rank_power_on  (rank_power_on),
        .rank_power_off (rank_power_off),
        .rank_awake     (rank_awake)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        q_v = '0; q_r = '0; q_rk = '0; done = '0;
        @(negedge clk);
        @(negedge clk);
        chk({rank_release, rel_entry_mask, rank_power_on, rank_power_off, rank_awake} == '0,
            "R9 outputs in reset", int'(rank_awake), 0);
        for (int r = 0; r < 4; r++) begin
            exp_out[r] = 0;
            exp_awake[r] = 0;
        end
        rst_n = 1'b1;
    endtask

    task automatic compute_exp(output logic [3:0] urg, output logic [3:0][7:0] msk);
        urg = '0;
        msk = '0;
        for (int i = 0; i < 8; i++) begin
            if (q_v[i]) begin
                msk[q_rk[2*i +: 2]][i] = 1'b1;
                if (q_r[i]) urg[q_rk[2*i +: 2]] = 1'b1;
            end
        end
    endtask

    task automatic wait_release(input int maxc, output bit found);
        found = 0;
        for (int c = 0; c < maxc; c++) begin
            @(negedge clk);
            if (rank_release != '0) begin
                found = 1;
                break;
            end
        end
    endtask

    // Called at the negedge where the first strobe is visible.
    task automatic run_phase(input logic [3:0] urg, input logic [3:0][7:0] msk);
        for (int r = 0; r < 4; r++) begin
            if (urg[r]) begin
                chk(rank_release == 4'(1 << r), "R5 strobe order", int'(rank_release), 1 << r);
                chk(rel_entry_mask == msk[r], "R3 released slots", int'(rel_entry_mask), int'(msk[r]));
                chk(rank_power_on == (exp_awake[r] ? 4'd0 : 4'(1 << r)), "R6 power-on pulse",
                    int'(rank_power_on), exp_awake[r] ? 0 : (1 << r));
                q_v = q_v & ~msk[r];
                exp_awake[r] = 1;
                exp_out[r] += $countones(msk[r]);
                @(negedge clk);
                chk(rank_awake[r] == 1'b1, "R6 awake after release", int'(rank_awake[r]), 1);
            end
        end
        chk(rank_release == '0, "R2 R8 no extra strobe", int'(rank_release), 0);
    endtask

    task automatic drain(input int r);
        if (exp_awake[r]) begin
            while (exp_out[r] > 0) begin
                chk(rank_power_off[r] == 1'b0, "R7 no off while outstanding", int'(rank_power_off[r]), 0);
                done = 4'(1 << r);
                @(negedge clk);
                done = '0;
                exp_out[r]--;
            end
            chk(rank_power_off == 4'(1 << r), "R7 off pulse at zero", int'(rank_power_off), 1 << r);
            @(negedge clk);
            chk(rank_awake[r] == 1'b0, "R7 asleep after off", int'(rank_awake[r]), 0);
            chk(rank_power_off == '0, "R7 off is a pulse", int'(rank_power_off), 0);
            exp_awake[r] = 0;
        end
    endtask

    task automatic load_pattern(input int s);
        for (int i = 0; i < 8; i++) begin
            q_v[i] = (s != 0) && (((s + i * 5) % 7) < 4);
            q_rk[2*i +: 2] = 2'((s + i * 3 + s / 5) % 4);
            q_r[i] = ((s * 11 + i * 7) % 9) < 2;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0]      urg;
        logic [3:0][7:0] msk;
        bit              found;

        // Sweep: read-presence decision and full-group release (R2, R3, R5, R6, R7)
        cfg = 16'd2;
        do_reset();
        for (int s = 0; s < 48; s++) begin
            @(negedge clk);
            load_pattern(s);
            compute_exp(urg, msk);
            if (urg == '0) begin
                wait_release(8, found);
                chk(!found, "R2 no strobe without read", int'(found), 0);
                chk(rank_awake == '0, "R2 ranks stay asleep", int'(rank_awake), 0);
            end else begin
                wait_release(8, found);
                chk(found, "R5 strobe after expiry", int'(found), 1);
                if (found) run_phase(urg, msk);
                for (int r = 0; r < 4; r++) drain(r);
            end
        end

        // R4: write-only slots parked, then released with a read
        cfg = 16'd2;
        do_reset();
        @(negedge clk);
        q_v = 8'b0000_0011; q_r = '0; q_rk = 16'h000F;
        wait_release(12, found);
        chk(!found, "R4 writes stay blocked", int'(found), 0);
        chk(rank_awake == '0, "R4 rank stays asleep", int'(rank_awake), 0);
        q_v[2] = 1'b1; q_r[2] = 1'b1; q_rk[5:4] = 2'd3;
        compute_exp(urg, msk);
        wait_release(8, found);
        chk(found && rel_entry_mask == 8'b0000_0111, "R4 writes released with read",
            int'(rel_entry_mask), 7);
        if (found) run_phase(urg, msk);
        drain(3);

        // R8 and R6: late arrivals wait; awake rank gets no power-on
        cfg = 16'd1;
        do_reset();
        @(negedge clk);
        q_v = 8'b0000_0111; q_r = 8'b0000_0011;
        q_rk = {10'd0, 2'd2, 2'd2, 2'd0};
        compute_exp(urg, msk);
        wait_release(8, found);
        chk(found, "R8 first phase starts", int'(found), 1);
        q_v[3] = 1'b1; q_r[3] = 1'b1; q_rk[7:6] = 2'd1;
        q_v[4] = 1'b1; q_r[4] = 1'b1; q_rk[9:8] = 2'd0;
        if (found) run_phase(urg, msk);
        chk(rank_awake[1] == 1'b0, "R8 late rank untouched", int'(rank_awake[1]), 0);
        compute_exp(urg, msk);
        wait_release(8, found);
        chk(found, "R8 late slots in next period", int'(found), 1);
        if (found) run_phase(urg, msk);
        for (int r = 0; r < 4; r++) drain(r);

        // R1: strobe timing at several delays
        for (int k = 0; k < 3; k++) begin
            int d;
            int last;
            int n;
            int cyc;
            d = (k == 0) ? 0 : ((k == 1) ? 3 : 9);
            cfg = 16'(d);
            do_reset();
            q_v = 8'b1; q_r = 8'b1; q_rk = '0;
            done = 4'b0001;
            last = 0;
            n = 0;
            cyc = 0;
            while (n < 3 && cyc < 60) begin
                @(negedge clk);
                cyc++;
                if (rank_release[0]) begin
                    if (n == 0) chk(cyc == d + 1, "R1 first expiry", cyc, d + 1);
                    else chk(cyc - last == d + 2, "R1 period spacing", cyc - last, d + 2);
                    last = cyc;
                    n++;
                end
            end
            chk(n == 3, "R1 periods seen", n, 3);
            done = '0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule